// File: doc/BRIEF.md
# Interrupt Status and Enable Aggregator

This block gathers the interrupt lines of up to sixteen local bus agents, plus an event raised whenever software writes the mailbox location, into one sticky status register. Each status bit has its own enable bit. When at least one bit is both set and enabled, the block asks a downstream PCI Express interrupt generator for service. It does this either as a held legacy level or as a single-cycle request strobe for message-signalled interrupts. The `msi_mode` pin picks the signalling style.

Software uses a small register port. It reads the status word, picks its own order of service, and clears the bits it has handled by writing ones to them. The hardware never ranks one source above another. Message formation and the link layer belong to the downstream generator.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous reset, every status bit and every enable bit is 0, and `intx_out`, `msi_req`, `csr_rvalid` and `csr_rdata` are 0.
- R2: When `irq_lines[i]` is high at a rising clock edge, status bit i is 1 from that edge onward. It stays 1 after the line falls, until software clears it.
- R3: Any write to the mailbox offset 0x080 sets status bit 16, whatever the write data. The written data is discarded.
- R4: A write to the status offset 0x040 clears each status bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R5: If a status bit is set by its source in the same cycle that a clear write targets it, the bit ends up 1.
- R6: The enable register lives at offset 0x050. It is written with data bits [16:0] and reads back those bits. Bits of unimplemented lines and bits 31:17 read as 0, and the register holds its value when not written.
- R7: With `msi_mode` = 0, `intx_out` is 1 exactly one cycle after a cycle in which any status bit is 1 together with its enable bit, and 0 one cycle after a cycle in which none is.
- R8: With `msi_mode` = 1, `msi_req` is high for one cycle, one cycle after the enabled-pending condition goes from false to true. It stays low while that condition remains true, and `intx_out` stays 0 in this mode.
- R9: A status bit whose enable bit is 0 is still recorded and readable, but raises neither `intx_out` nor `msi_req`.
- R10: Several status bits may be set in the same cycle. All of them are kept, with no ordering among them.
- R11: A read (`csr_rd` = 1) returns its data in `csr_rdata` on the next cycle with `csr_rvalid` = 1. The status word comes from 0x040 and the enable word from 0x050. Any other offset returns 0, and `csr_rdata` is 0 in cycles without a read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Level interrupt lines from local agents |
| msi_mode | input | 1 | 1 selects single-cycle message requests, 0 selects legacy level |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_addr | input | ADDR_W | Register byte offset |
| csr_wdata | input | DATA_W | Register write data |
| csr_rdata | output | DATA_W | Registered read data |
| csr_rvalid | output | 1 | Read data valid, one cycle after `csr_rd` |
| intx_out | output | 1 | Legacy interrupt level |
| msi_req | output | 1 | Message interrupt request strobe |

## Verification
The embedded properties watch every cycle for several things. Set bits must stay set unless a clear targets them, and a source event must override a same-cycle clear. The mailbox write must land in bit 16. The enable register must not move without a write. The legacy level must track the enabled-pending condition with one cycle of delay, and the message strobe must never last two cycles or appear together with the level. Other behaviour only shows up in the bench's scenarios against its behavioural model. That covers the exact value read back after mixed set and clear traffic, masking of bits by their enables, and the count of strobes when a second source arrives while one is already pending. It also covers re-arming after the pending condition drops, and the zero returned for an unmapped offset.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int STAT_W   = 17;
  localparam int MBOX_BIT = 16;

  typedef enum logic {
    SIG_LEGACY = 1'b0,
    SIG_MSI    = 1'b1
  } sig_mode_e;

  typedef struct packed {
    logic [STAT_W-1:0] clr;
    logic              mbox_hit;
    logic              en_we;
    logic [STAT_W-1:0] en_val;
  } csr_cmd_t;

  function automatic logic [STAT_W-1:0] impl_mask(input int n_lines);
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < MBOX_BIT; i++) begin
      if (i < n_lines) m[i] = 1'b1;
    end
    m[MBOX_BIT] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irqagg_pkg::*;
#(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines,
  input  logic                 mbox_set,
  input  logic [STAT_W-1:0]    clr,
  output logic [STAT_W-1:0]    status
);

  logic [STAT_W-1:0] set_vec;

  // Route each source to its status bit; unused positions never set.
  for (genvar g = 0; g < STAT_W; g++) begin : g_src
    if (g < NUM_LINES) begin : g_line
      assign set_vec[g] = lines[g];
    end else if (g == MBOX_BIT) begin : g_mbox
      assign set_vec[g] = mbox_set;
    end else begin : g_none
      assign set_vec[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr) | set_vec;
  end

  // R2: a set bit survives unless a clear targets it
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(status) & ~$past(clr)) & ~status) == '0);

  // R5, R10: every source event lands, even against a clear
  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($past(set_vec) & ~status) == '0);

  // R3: mailbox event reaches bit 16
  p_mbox_r3: assert property (@(posedge clk) disable iff (rst)
    mbox_set |=> status[MBOX_BIT]);

endmodule

// File: rtl/irq_csr_port.sv
module irq_csr_port
  import irqagg_pkg::*;
#(
  parameter int              NUM_LINES = 16,
  parameter int              ADDR_W    = 12,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h040,
  parameter logic [ADDR_W-1:0] EN_OFS   = 12'h050,
  parameter logic [ADDR_W-1:0] MBOX_OFS = 12'h080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] enable,
  output logic [STAT_W-1:0] clr,
  output logic              mbox_set,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  localparam logic [STAT_W-1:0] MASK = impl_mask(NUM_LINES);

  csr_cmd_t cmd;
  logic     unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:STAT_W];

  always_comb begin
    cmd          = '0;
    cmd.clr      = (wr && addr == STAT_OFS) ? wdata[STAT_W-1:0] : '0;
    cmd.mbox_hit = wr && addr == MBOX_OFS;
    cmd.en_we    = wr && addr == EN_OFS;
    cmd.en_val   = wdata[STAT_W-1:0] & MASK;
  end

  assign clr      = cmd.clr;
  assign mbox_set = cmd.mbox_hit;

  always_ff @(posedge clk) begin
    if (rst)            enable <= '0;
    else if (cmd.en_we) enable <= cmd.en_val;
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (addr == STAT_OFS)    rd_mux[STAT_W-1:0] = status;
    else if (addr == EN_OFS) rd_mux[STAT_W-1:0] = enable;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= rd ? rd_mux : '0;
      rvalid <= rd;
    end
  end

  // R6: enable changes only through its own write
  p_en_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !cmd.en_we |=> $stable(enable));

  // R11: each read yields a response one cycle later
  p_rvalid_r11: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);

  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !rd |=> rdata == '0);

endmodule

// File: rtl/irq_notify.sv
module irq_notify
  import irqagg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              msi_mode,
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] enable,
  output logic              intx_out,
  output logic              msi_req
);

  sig_mode_e mode;
  logic      pending;
  logic      pend_prev;

  assign mode    = sig_mode_e'(msi_mode);
  assign pending = |(status & enable);

  always_ff @(posedge clk) begin
    if (rst) begin
      intx_out  <= 1'b0;
      msi_req   <= 1'b0;
      pend_prev <= 1'b0;
    end else begin
      pend_prev <= pending;
      intx_out  <= (mode == SIG_LEGACY) && pending;
      msi_req   <= (mode == SIG_MSI) && pending && !pend_prev;
    end
  end

  // R7: legacy level follows the enabled-pending condition
  p_intx_up_r7: assert property (@(posedge clk) disable iff (rst)
    (!msi_mode && pending) |=> intx_out);

  p_intx_down_r7: assert property (@(posedge clk) disable iff (rst)
    !pending |=> !intx_out);

  // R8: strobe lasts one cycle and excludes the level
  p_msi_single_r8: assert property (@(posedge clk) disable iff (rst)
    msi_req |=> !msi_req);

  p_mode_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(msi_req && intx_out));

  // R9: nothing enabled and pending means no request
  p_masked_r9: assert property (@(posedge clk) disable iff (rst)
    !pending |=> !msi_req);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int                NUM_LINES = 16,
  parameter int                ADDR_W    = 12,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS  = 12'h040,
  parameter logic [ADDR_W-1:0] EN_OFS    = 12'h050,
  parameter logic [ADDR_W-1:0] MBOX_OFS  = 12'h080
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 msi_mode,
  input  logic                 csr_wr,
  input  logic                 csr_rd,
  input  logic [ADDR_W-1:0]    csr_addr,
  input  logic [DATA_W-1:0]    csr_wdata,
  output logic [DATA_W-1:0]    csr_rdata,
  output logic                 csr_rvalid,
  output logic                 intx_out,
  output logic                 msi_req
);

  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] enable;
  logic [STAT_W-1:0] clr;
  logic              mbox_set;

  irq_csr_port #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STAT_OFS(STAT_OFS), .EN_OFS(EN_OFS), .MBOX_OFS(MBOX_OFS)
  ) u_csr (
    .clk(clk), .rst(rst), .wr(csr_wr), .rd(csr_rd), .addr(csr_addr),
    .wdata(csr_wdata), .status(status), .enable(enable), .clr(clr),
    .mbox_set(mbox_set), .rdata(csr_rdata), .rvalid(csr_rvalid)
  );

  irq_status_bank #(.NUM_LINES(NUM_LINES)) u_stat (
    .clk(clk), .rst(rst), .lines(irq_lines), .mbox_set(mbox_set),
    .clr(clr), .status(status)
  );

  irq_notify u_notify (
    .clk(clk), .rst(rst), .msi_mode(msi_mode), .status(status),
    .enable(enable), .intx_out(intx_out), .msi_req(msi_req)
  );

  // R1: quiet outputs right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!intx_out && !msi_req && !csr_rvalid));

endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;

  localparam int NL = 16;
  localparam logic [11:0] A_STAT = 12'h040;
  localparam logic [11:0] A_EN   = 12'h050;
  localparam logic [11:0] A_MBOX = 12'h080;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NL-1:0] lines = '0;
  logic        msi_mode = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, intx, msi;

  always #2.5 clk = ~clk;

  irq_aggregator u0 (
    .clk(clk), .rst(rst), .irq_lines(lines), .msi_mode(msi_mode),
    .csr_wr(wr), .csr_rd(rd), .csr_addr(addr), .csr_wdata(wdata),
    .csr_rdata(rdata), .csr_rvalid(rvalid), .intx_out(intx), .msi_req(msi)
  );

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  int msi_cnt = 0;
  bit done = 0;

  // behavioural reference
  int unsigned m_stat, m_en, m_rdata;
  bit m_prev, m_intx, m_msi, m_rvalid;

  always @(posedge clk) begin
    bit pend;
    if (rst) begin
      m_stat = 0; m_en = 0; m_rdata = 0;
      m_prev = 0; m_intx = 0; m_msi = 0; m_rvalid = 0;
    end else begin
      pend = (m_stat & m_en) != 0;
      m_rvalid = rd;
      if (!rd) m_rdata = 0;
      else if (addr == A_STAT) m_rdata = m_stat;
      else if (addr == A_EN) m_rdata = m_en;
      else m_rdata = 0;
      m_intx = !msi_mode && pend;
      m_msi  = msi_mode && pend && !m_prev;
      m_prev = pend;
      if (wr && addr == A_STAT) m_stat = m_stat & ~(wdata & 32'h1FFFF);
      m_stat = m_stat | 32'(lines);
      if (wr && addr == A_MBOX) m_stat = m_stat | 32'h10000;
      if (wr && addr == A_EN) m_en = wdata & 32'h1FFFF;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (msi) msi_cnt++;
    if (!done) begin
      chk(intx == m_intx, "R7 intx per-cycle", 32'(intx), 32'(m_intx));
      chk(msi == m_msi, "R8 msi per-cycle", 32'(msi), 32'(m_msi));
      chk(rvalid == m_rvalid, "R11 rvalid per-cycle", 32'(rvalid), 32'(m_rvalid));
      chk(rdata == m_rdata, "R11 rdata per-cycle", rdata, m_rdata);
    end
    if (cycles > 100000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; addr = '0; wdata = '0;
  endtask

  task automatic csr_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; addr = '0;
    d = rdata;
    chk(rvalid == 1'b1, "R11 rvalid on read", 32'(rvalid), 32'h1);
  endtask

  task automatic pulse(input logic [NL-1:0] m);
    @(negedge clk); lines = m;
    @(negedge clk); lines = '0;
  endtask

  initial begin
    logic [31:0] v;
    int c0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!intx && !msi && !rvalid && rdata == 0, "R1 outputs after reset",
        {intx, msi, rvalid, |rdata}, 0);
    csr_read(A_STAT, v); chk(v == 0, "R1 status after reset", v, 0);
    csr_read(A_EN, v);   chk(v == 0, "R1 enable after reset", v, 0);

    // legacy, disabled bit recorded
    pulse(16'h0008);
    @(negedge clk);
    chk(intx == 0, "R9 disabled bit no intx", 32'(intx), 0);
    csr_read(A_STAT, v); chk(v == 32'h8, "R2 sticky line bit", v, 32'h8);
    csr_write(A_EN, 32'h8);
    @(negedge clk);
    chk(intx == 1, "R7 intx asserted", 32'(intx), 1);
    csr_write(A_STAT, 32'h0);
    csr_read(A_STAT, v); chk(v == 32'h8, "R4 zero bits keep status", v, 32'h8);
    csr_write(A_STAT, 32'h8);
    @(negedge clk);
    chk(intx == 0, "R7 intx released", 32'(intx), 0);
    csr_read(A_STAT, v); chk(v == 0, "R4 w1c cleared", v, 0);

    // simultaneous sources
    pulse(16'h8022);
    csr_read(A_STAT, v); chk(v == 32'h8022, "R10 multiple bits", v, 32'h8022);

    // mailbox
    csr_write(A_MBOX, 32'hDEAD0000);
    csr_read(A_STAT, v); chk(v == 32'h18022, "R3 mailbox bit16", v, 32'h18022);
    chk(intx == 0, "R9 masked bits no intx", 32'(intx), 0);
    csr_write(A_EN, 32'h10000);
    @(negedge clk);
    chk(intx == 1, "R3 mailbox raises intx", 32'(intx), 1);

    // enable readback
    csr_write(A_EN, 32'hFFFFFFFF);
    csr_read(A_EN, v); chk(v == 32'h1FFFF, "R6 enable readback", v, 32'h1FFFF);
    csr_write(A_STAT, 32'h1FFFF);
    csr_read(A_STAT, v); chk(v == 0, "R4 clear all", v, 0);

    // set against clear in one cycle
    @(negedge clk); lines = 16'h0080; wr = 1; addr = A_STAT; wdata = 32'h80;
    @(negedge clk); lines = '0; wr = 0; addr = '0; wdata = '0;
    csr_read(A_STAT, v); chk(v == 32'h80, "R5 set beats clear", v, 32'h80);
    csr_write(A_STAT, 32'h80);

    csr_read(12'h044, v); chk(v == 0, "R11 unmapped read", v, 0);

    // MSI mode
    @(negedge clk); msi_mode = 1;
    repeat (2) @(negedge clk);
    c0 = msi_cnt;
    pulse(16'h0004);
    repeat (4) @(negedge clk);
    chk(msi_cnt - c0 == 1, "R8 one strobe", 32'(msi_cnt - c0), 1);
    chk(intx == 0, "R8 intx held low in msi", 32'(intx), 0);
    pulse(16'h0200);
    repeat (3) @(negedge clk);
    chk(msi_cnt - c0 == 1, "R8 no strobe while pending", 32'(msi_cnt - c0), 1);
    csr_write(A_STAT, 32'h1FFFF);
    repeat (2) @(negedge clk);
    pulse(16'h0010);
    repeat (3) @(negedge clk);
    chk(msi_cnt - c0 == 2, "R8 re-armed strobe", 32'(msi_cnt - c0), 2);

    @(negedge clk); msi_mode = 0;
    repeat (2) @(negedge clk);
    chk(intx == 1, "R7 back to legacy level", 32'(intx), 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule